// File: doc/BRIEF.md
# Next-Frame-Reply SPI Register Master

This block is an SPI master for a sensor that answers a 32-bit request one frame later, not inside the same frame. A controller hands it a register command (write or read, capture flag, 8-bit address, 16-bit write value). The block wraps the command into a 32-bit request word with a 3-bit CRC and clocks it out MSB first in SPI mode 0. A write ends after that one frame. A read needs a second frame: chip select is released for a minimum gap, then another 32 bits are clocked with MOSI held at zero, and the sensor's reply is captured from MISO during that frame.

The reply is checked before it is returned. The CRC remainder over all 32 reply bits must be zero, and the reply must not have both its status bit 31 and its flag bit 3 set. The 16-bit payload from bits 19:4 then appears on the response port with a one-cycle done pulse. Any failed check raises the error flag instead. Scheduling of multi-register bursts belongs to an outside controller that issues one command at a time.

The command port is valid/ready. Ready is high only while the block is idle, so a controller holding valid simply waits, and no command is queued internally. The response port has no back-pressure: the done pulse lasts one cycle and the read data and error flag stay valid until the next done.

Top module: `oof_spi_master`

## Requirements
- R1: The request word is {bus id 2'b00 in bits 31:30, address in 29:22, write flag in 21, capture flag in 20, 0 in 19, data in 18:3, CRC in 2:0}. Data bits are zero for reads. The CRC runs over bits 31:0 with bits 2:0 taken as zero, MSB first, starting from 3'b101. On each bit the register shifts left, takes the bit into its LSB, and is XORed with 3'b011 when the bit shifted out was 1. The result is placed in bits 2:0.
- R2: A read uses two frames. The second frame drives MOSI low for all 32 bits.
- R3: A write uses exactly one frame. Its done pulse carries error 0 and read data 0.
- R4: For a valid read reply, the read data equals reply bits 19:4.
- R5: A read reply is rejected (error 1, read data 0) when the CRC of R1 over all 32 reply bits is not zero, or when reply bits 31 and 3 are both 1. A reply with only one of those two bits set is accepted.
- R6: Between frames, chip select stays high for longer than GAP_NS. The gap is counted in whole clock cycles: floor(GAP_NS·CLK_HZ/1e9)+1.
- R7: SPI mode 0 is used. SCLK is low whenever chip select is high, MOSI changes only while SCLK is low, and MISO is sampled on SCLK rising edges. Each frame has exactly 32 rising edges.
- R8: cmd_ready is high only while no command is in progress. After a command is accepted, ready stays low until its done pulse.
- R9: Every accepted command produces exactly one done pulse, and the pulse lasts one clock cycle.
- R10: After reset, chip select is high, SCLK is low, cmd_ready is high and rsp_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid is also high |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_capture | input | 1 | Capture flag placed in request bit 20 |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 16 | Write value (ignored for reads) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Reply rejected (reads only) |
| rsp_rdata | output | 16 | Read data, 0 for writes and rejected replies |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the sensor |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the sensor |

## Verification
Directed commands cover the corners: all-ones address and data, the capture flag, and replies with only bit 31, only bit 3, or both set. These show whether the status rule looks at the pair of bits or at each bit alone. Random mixes of reads and writes use random addresses and payloads. For each read, the sensor model sends a decoy word in the first frame and the true reply in the second, so a design that reads the wrong frame is caught. Replies with a single flipped bit test the CRC reject. Each captured request is compared bit for bit with a word the bench builds, which checks field placement and CRC together. Every chip-select gap is timed.

// File: rtl/oof_spi_pkg.sv
package oof_spi_pkg;
  localparam int FRAME_W   = 32;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int CRC_W     = 3;
  localparam logic [CRC_W-1:0] CRC_SEED = 3'b101;
  localparam logic [CRC_W-1:0] CRC_TAPS = 3'b011;
  localparam int RD_LSB    = 4;
  localparam int WR_LSB    = 3;
  localparam int POS_WRITE = 21;
  localparam int POS_CAPT  = 20;
  localparam int POS_ADDR  = 22;
  localparam int POS_STAT  = 31;
  localparam int POS_FLAG  = 3;

  typedef enum logic [1:0] {M_IDLE, M_REQ, M_RPLY} mst_state_t;
  typedef enum logic [1:0] {E_IDLE, E_XFER, E_GAP} eng_state_t;

  // Remainder of a 32-bit word, MSB first, seeded register
  function automatic logic [CRC_W-1:0] crc3(input logic [FRAME_W-1:0] w);
    logic [CRC_W-1:0] c;
    logic             top;
    c = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      top = c[CRC_W-1];
      c   = {c[CRC_W-2:0], w[i]};
      if (top) c = c ^ CRC_TAPS;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] make_request(
      input logic [1:0]        bus_id,
      input logic              wr,
      input logic              capt,
      input logic [ADDR_W-1:0] addr,
      input logic [DATA_W-1:0] wdata);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[FRAME_W-1 -: 2]             = bus_id;
    w[POS_ADDR +: ADDR_W]         = addr;
    w[POS_WRITE]                  = wr;
    w[POS_CAPT]                   = capt;
    w[WR_LSB +: DATA_W]           = wr ? wdata : '0;
    w[CRC_W-1:0]                  = crc3(w);
    return w;
  endfunction
endpackage

// File: rtl/oof_sclk_tick.sv
module oof_sclk_tick #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/oof_frame_engine.sv
module oof_frame_engine
  import oof_spi_pkg::*;
#(
  parameter int HALF_CYC = 5,
  parameter int GAP_CYC  = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

  eng_state_t         st_q;
  logic [BW-1:0]      bit_q;
  logic [GW-1:0]      gap_q;
  logic [FRAME_W-1:0] sh_q, rx_q;
  logic               sclk_q, cs_q, done_q;
  logic               run, tick;

  assign run = (st_q == E_XFER);

  oof_sclk_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      bit_q  <= '0;
      gap_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        E_IDLE: if (start) begin
          sh_q  <= tx_word;
          bit_q <= '0;
          cs_q  <= 1'b0;
          st_q  <= E_XFER;
        end
        E_XFER: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[FRAME_W-2:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == BIT_LAST) begin
              cs_q  <= 1'b1;
              gap_q <= '0;
              st_q  <= E_GAP;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            end
          end
        end
        E_GAP: begin
          if (gap_q == GAP_LAST) begin
            done_q <= 1'b1;
            st_q   <= E_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = !cs_q && sh_q[FRAME_W-1];
  assign done    = done_q;
  assign rx_word = rx_q;

  // Checker state: consecutive chip-select-high cycles, saturating
  logic [GW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_cnt_q <= GW'(GAP_CYC);
    else if (!cs_q)                   hi_cnt_q <= '0;
    else if (hi_cnt_q < GW'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_cnt_q >= GW'(GAP_CYC)));
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && sclk_q) |=> (!sclk_q || $stable(mosi)));
endmodule

// File: rtl/oof_reply_check.sv
module oof_reply_check
  import oof_spi_pkg::*;
(
  input  logic [FRAME_W-1:0] reply,
  output logic               ok,
  output logic [DATA_W-1:0]  payload
);
  logic crc_bad, stat_bad;

  always_comb begin
    crc_bad  = (crc3(reply) != '0);
    stat_bad = reply[POS_STAT] && reply[POS_FLAG];
    ok       = !crc_bad && !stat_bad;
    payload  = reply[RD_LSB +: DATA_W];
  end
endmodule

// File: rtl/oof_spi_master.sv
module oof_spi_master
  import oof_spi_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int SCLK_HZ = 5_000_000,
  parameter int GAP_NS  = 700,
  parameter logic [1:0] BUS_ID = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic        cmd_capture,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        rsp_done,
  output logic        rsp_error,
  output logic [15:0] rsp_rdata,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int HALF_RAW = (CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam longint GAP_PROD = longint'(GAP_NS) * longint'(CLK_HZ);
  localparam int GAP_CYC  = int'(GAP_PROD / 64'sd1000000000) + 1;

  mst_state_t         st_q;
  logic               start_q, wr_q;
  logic [FRAME_W-1:0] tx_q, rx_word;
  logic               eng_done, rep_ok;
  logic [DATA_W-1:0]  rep_data;
  logic               done_q, err_q;
  logic [DATA_W-1:0]  rdata_q;

  oof_frame_engine #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_q),
    .tx_word(tx_q),
    .miso   (miso),
    .sclk   (sclk),
    .mosi   (mosi),
    .cs_n   (cs_n),
    .done   (eng_done),
    .rx_word(rx_word)
  );

  oof_reply_check u_chk (
    .reply  (rx_word),
    .ok     (rep_ok),
    .payload(rep_data)
  );

  assign cmd_ready = (st_q == M_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      start_q <= 1'b0;
      wr_q    <= 1'b0;
      tx_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st_q)
        M_IDLE: if (cmd_valid) begin
          tx_q    <= make_request(BUS_ID, cmd_write, cmd_capture, cmd_addr, cmd_wdata);
          wr_q    <= cmd_write;
          start_q <= 1'b1;
          st_q    <= M_REQ;
        end
        M_REQ: if (eng_done) begin
          if (wr_q) begin
            done_q  <= 1'b1;
            err_q   <= 1'b0;
            rdata_q <= '0;
            st_q    <= M_IDLE;
          end else begin
            tx_q    <= '0;
            start_q <= 1'b1;
            st_q    <= M_RPLY;
          end
        end
        M_RPLY: if (eng_done) begin
          done_q  <= 1'b1;
          err_q   <= !rep_ok;
          rdata_q <= rep_ok ? rep_data : '0;
          st_q    <= M_IDLE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign rsp_done  = done_q;
  assign rsp_error = err_q;
  assign rsp_rdata = rdata_q;

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r2_reply_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_RPLY && !cs_n) |-> !mosi);
  a_r5_error_clears_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_error) |-> (rsp_rdata == '0));
  a_r3_write_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && wr_q) |-> (!rsp_error && rsp_rdata == '0));
endmodule

// File: tb/oof_spi_master_tb.sv
`timescale 1ns/1ps
module oof_spi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_capture = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_done, rsp_error, sclk, mosi, cs_n;
  logic [15:0] rsp_rdata;
  logic        miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  oof_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_capture(cmd_capture), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Polynomial division as the requirement states it
  function automatic logic [2:0] ref_crc(input logic [31:0] w);
    logic [2:0] r = 3'b101;
    for (int k = 31; k >= 0; k--) begin
      logic hi = r[2];
      r = {r[1:0], w[k]};
      r = hi ? (r ^ 3'b011) : r;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_req(input bit wr, input bit cap,
      input logic [7:0] a, input logic [15:0] d);
    logic [31:0] w = {2'b00, a, wr, cap, 1'b0, (wr ? d : 16'h0), 3'b000};
    return w | {29'h0, ref_crc(w)};
  endfunction

  function automatic logic [31:0] ref_reply(input bit sd, input logic [10:0] junk,
      input logic [15:0] d, input bit flag);
    logic [31:0] w = {sd, junk, d, flag, 3'b000};
    return w | {29'h0, ref_crc(w)};
  endfunction

  // Sensor model and bus monitor
  logic [31:0] reply_a, reply_b, sl_sh, cap_sh;
  logic [31:0] frames [0:3];
  int   fidx = 0, cap_bits = 0;
  bit   in_frame = 0, have_rise = 0;
  realtime t_rise;

  always @(negedge cs_n) begin
    if (have_rise)
      chk(($realtime - t_rise) > 700.0, "R6 cs gap ns", 32'($rtoi($realtime - t_rise)), 32'd701);
    in_frame = 1;
    cap_bits = 0;
    sl_sh = (fidx == 0) ? reply_a : reply_b;
    miso = sl_sh[31];
  end
  always @(negedge sclk) if (!cs_n) begin
    sl_sh = {sl_sh[30:0], 1'b0};
    miso = sl_sh[31];
  end
  always @(posedge sclk) begin
    if (cs_n) chk(0, "R7 sclk high with cs_n high", 32'h1, 32'h0);
    else begin
      cap_sh = {cap_sh[30:0], mosi};
      cap_bits++;
    end
  end
  always @(posedge cs_n) if (in_frame) begin
    chk(cap_bits == 32, "R7 rising edges per frame", 32'(cap_bits), 32'd32);
    if (fidx < 4) frames[fidx] = cap_sh;
    fidx++;
    in_frame = 0;
    have_rise = 1;
    t_rise = $realtime;
  end

  task automatic run_cmd(input bit wr, input bit cap, input logic [7:0] a,
      input logic [15:0] d, input logic [31:0] rep, input bit exp_err,
      input logic [15:0] exp_data);
    int wait_n = 0;
    reply_a = ~rep ^ 32'h00F0_0F00;
    reply_b = rep;
    fidx = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_capture = cap; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_wdata = $urandom; cmd_addr = $urandom;
    chk(!cmd_ready, "R8 ready low while busy", 32'(cmd_ready), 32'h0);
    while (!rsp_done && wait_n < 5000) begin @(negedge clk); wait_n++; end
    chk(rsp_done, "R9 done pulse seen", 32'(rsp_done), 32'h1);
    chk(fidx == (wr ? 1 : 2), wr ? "R3 write frame count" : "R2 read frame count",
        32'(fidx), wr ? 32'd1 : 32'd2);
    chk(frames[0] == ref_req(wr, cap, a, d), "R1 request word", frames[0], ref_req(wr, cap, a, d));
    if (!wr) begin
      chk(frames[1] == 32'h0, "R2 second frame mosi zero", frames[1], 32'h0);
      chk(rsp_error == exp_err, "R5 error flag", 32'(rsp_error), 32'(exp_err));
      chk(rsp_rdata == exp_data, "R4 read data", 32'(rsp_rdata), 32'(exp_data));
    end else begin
      chk(!rsp_error && rsp_rdata == 0, "R3 write response", {15'h0, rsp_error, rsp_rdata}, 32'h0);
    end
    @(negedge clk);
    chk(!rsp_done, "R9 pulse one cycle", 32'(rsp_done), 32'h0);
    chk(cmd_ready, "R8 ready after done", 32'(cmd_ready), 32'h1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && cmd_ready && !rsp_done, "R10 reset state",
        {28'h0, cs_n, sclk, cmd_ready, rsp_done}, 32'h0000_000A);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && cmd_ready && !rsp_done, "R10 idle after reset",
        {28'h0, cs_n, sclk, cmd_ready, rsp_done}, 32'h0000_000A);

    // Directed corners
    run_cmd(1, 0, 8'h2F, 16'h00B6, 32'h0, 0, 16'h0);
    run_cmd(1, 1, 8'hFF, 16'hFFFF, 32'h0, 0, 16'h0);
    run_cmd(0, 0, 8'h00, 16'hABCD, ref_reply(0, 11'h0, 16'h0024, 0), 0, 16'h0024);
    run_cmd(0, 1, 8'h17, 16'h0, ref_reply(1, 11'h155, 16'h8001, 0), 0, 16'h8001);   // R5 stat only
    run_cmd(0, 0, 8'h11, 16'h0, ref_reply(0, 11'h2AA, 16'h7FFE, 1), 0, 16'h7FFE);   // R5 flag only
    run_cmd(0, 0, 8'h14, 16'h0, ref_reply(1, 11'h0, 16'h1234, 1), 1, 16'h0);        // R5 both set
    r = ref_reply(0, 11'h3, 16'h5A5A, 0) ^ 32'h0000_0100;
    run_cmd(0, 0, 8'h10, 16'h0, r, 1, 16'h0);                                        // R5 crc bad
    run_cmd(0, 1, 8'hFF, 16'h0, ref_reply(0, 11'h7FF, 16'hFFFF, 0), 0, 16'hFFFF);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit wr = $urandom_range(0, 2) == 0;
      bit cap = $urandom_range(0, 1) == 1;
      logic [7:0] a = $urandom;
      logic [15:0] d = $urandom;
      int kind = $urandom_range(0, 3);
      bit sd = $urandom_range(0, 1) == 1;
      bit fl = (kind == 2) ? 1'b1 : (sd ? 1'b0 : ($urandom_range(0, 1) == 1));
      logic [15:0] pd = $urandom;
      if (kind == 2) sd = 1;
      r = ref_reply(sd, 11'($urandom), pd, fl);
      if (kind == 1) r = r ^ (32'h1 << $urandom_range(4, 30));
      run_cmd(wr, cap, a, d, r, (kind == 1 || kind == 2), (kind == 1 || kind == 2) ? 16'h0 : pd);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule